// File: doc/BRIEF.md
# GPIO Output Latch and Pin Readback Register Block

This block gives software a small set of memory-mapped registers for a row of general-purpose lines. Every line is an output driven from a latch. Writing the data word loads the whole latch. Reading the data word returns what is present on the input pins, after a two-stage synchroniser. The number of lines equals the register width, which is a build-time choice of 8, 16, 32 or 64 bits.

The bus is a minimal port: a word address, a write strobe, write data and read data. A write takes effect at the clock edge on which the strobe is high. Read data is a combinational function of the address, so it is valid in the same cycle. A build option adds two write-only mask registers. Ones written to the first mask force the matching latch bits high, and ones written to the second force them low. A single line can then change without a read-modify-write of the data word.

A second build option reverses the numbering between register bits and lines, so that line 0 sits in the most significant register bit. The block has no state machine. Its only sequential state is the output latch and the synchroniser chain, and the address decode is an enumerated register select.

Top module: `gpio_mmio`

## Requirements
- R1: While reset is asserted and after it is released, every bit of `pin_out` is 0 until the first write.
- R2: A write to word address 0 loads the whole latch with `bus_wdata`, and `pin_out` shows the new value from the clock edge of the write onward.
- R3: A read at word address 0 returns the `pin_in` value seen two rising clock edges earlier; after only one edge the previous value is still returned.
- R4: With set and clear enabled, a write to word address 1 forces to 1 every latch bit whose `bus_wdata` bit is 1, and leaves all other bits unchanged.
- R5: With set and clear enabled, a write to word address 2 forces to 0 every latch bit whose `bus_wdata` bit is 1, and leaves all other bits unchanged.
- R6: In any cycle without a write strobe, the latch and `pin_out` hold their value.
- R7: Reads at word addresses 1, 2 and 3 return all zeros, and a write to address 3 leaves the latch unchanged.
- R8: With set and clear disabled, writes to word addresses 1 and 2 leave the latch unchanged.
- R9: In normal order, register bit n corresponds to line n, both for `pin_out` and for the read value of `pin_in`.
- R10: In reversed order, register bit WIDTH-1-n corresponds to line n, both for `pin_out` and for the read value of `pin_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Word address: 0 data, 1 set mask, 2 clear mask, 3 unused |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | WIDTH | Write data or mask |
| bus_rdata | output | WIDTH | Read data, combinational from the address |
| pin_in | input | WIDTH | Asynchronous line inputs, indexed by line number |
| pin_out | output | WIDTH | Line outputs from the latch, indexed by line number |

## Verification
A write changes `pin_out` at the rising edge of its strobe, so the bench drives each write on a falling edge and checks the outputs on the next falling edge. Read data depends only on the address and the synchroniser output, so it is sampled a short delay after the address is driven, in the same cycle. A change on `pin_in` takes two rising edges to reach the read path. The bench therefore checks after one edge that the old value is still returned, and after the second edge that the new value is returned. Two instances, one in normal order with set and clear and one in reversed order without them, cover both build variants.

// File: rtl/gpio_mmio_pkg.sv
package gpio_mmio_pkg;

    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA = 2'd0,
        REG_SET  = 2'd1,
        REG_CLR  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] addr);
        return reg_sel_e'(addr);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_order.sv
module gpio_order #(
    parameter int unsigned WIDTH    = 32,
    parameter bit          REVERSED = 1'b0
) (
    input  logic [WIDTH-1:0] vec_in,
    output logic [WIDTH-1:0] vec_out
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (REVERSED) begin : g_rev
            assign vec_out[i] = vec_in[WIDTH-1-i];
        end else begin : g_fwd
            assign vec_out[i] = vec_in[i];
        end
    end

endmodule

// File: rtl/gpio_latch.sv
module gpio_latch
    import gpio_mmio_pkg::*;
#(
    parameter int unsigned WIDTH      = 32,
    parameter bit          HAS_SETCLR = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] latch_q
);

    logic [WIDTH-1:0] set_mask;
    logic [WIDTH-1:0] clr_mask;
    logic             load_en;
    logic [WIDTH-1:0] latch_d;

    assign load_en = wr && (sel == REG_DATA);

    if (HAS_SETCLR) begin : g_setclr
        assign set_mask = (wr && sel == REG_SET) ? wdata : '0;
        assign clr_mask = (wr && sel == REG_CLR) ? wdata : '0;
    end else begin : g_nosetclr
        assign set_mask = '0;
        assign clr_mask = '0;
    end

    always_comb begin
        latch_d = latch_q;
        unique case (sel)
            REG_DATA: if (load_en) latch_d = wdata;
            REG_SET:  latch_d = latch_q | set_mask;
            REG_CLR:  latch_d = latch_q & ~clr_mask;
            REG_NONE: latch_d = latch_q;
            default:  latch_d = latch_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= latch_d;
    end

    // R2
    data_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == REG_DATA) |=> latch_q == $past(wdata));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(latch_q));

    // R7
    none_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == REG_NONE) |=> $stable(latch_q));

    if (HAS_SETCLR) begin : g_setclr_chk
        // R4
        set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && sel == REG_SET) |=>
                ((latch_q & $past(wdata)) == $past(wdata)) &&
                ((latch_q & ~$past(wdata)) == ($past(latch_q) & ~$past(wdata))));
        // R5
        clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && sel == REG_CLR) |=>
                ((latch_q & $past(wdata)) == '0) &&
                ((latch_q & ~$past(wdata)) == ($past(latch_q) & ~$past(wdata))));
    end else begin : g_nosetclr_chk
        // R8
        absent_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && (sel == REG_SET || sel == REG_CLR)) |=> $stable(latch_q));
    end

endmodule

// File: rtl/gpio_mmio.sv
module gpio_mmio
    import gpio_mmio_pkg::*;
#(
    parameter int unsigned WIDTH       = 32,
    parameter bit          HAS_SETCLR  = 1'b1,
    parameter bit          REVERSED    = 1'b0,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out
);

    reg_sel_e         sel;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] pins_sync;
    logic [WIDTH-1:0] pins_reg;

    initial begin
        width_legal_chk: assert (WIDTH == 8 || WIDTH == 16 || WIDTH == 32 || WIDTH == 64);
    end

    assign sel = decode_addr(bus_addr);

    gpio_latch #(
        .WIDTH      (WIDTH),
        .HAS_SETCLR (HAS_SETCLR)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .sel     (sel),
        .wdata   (bus_wdata),
        .latch_q (latch_q)
    );

    gpio_order #(
        .WIDTH    (WIDTH),
        .REVERSED (REVERSED)
    ) u_out_order (
        .vec_in  (latch_q),
        .vec_out (pin_out)
    );

    gpio_sync #(
        .WIDTH  (WIDTH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pins_sync)
    );

    gpio_order #(
        .WIDTH    (WIDTH),
        .REVERSED (REVERSED)
    ) u_in_order (
        .vec_in  (pins_sync),
        .vec_out (pins_reg)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            REG_DATA: bus_rdata = pins_reg;
            REG_SET,
            REG_CLR,
            REG_NONE: bus_rdata = '0;
            default:  bus_rdata = '0;
        endcase
    end

    // R7
    rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != 2'd0) |-> bus_rdata == '0);

    // R6
    pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(pin_out));

endmodule

// File: tb/gpio_mmio_bench.sv
module gpio_mmio_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [1:0]  a_addr = '0;
    logic        a_wr = 1'b0;
    logic [31:0] a_wdata = '0, a_rdata, a_pin_in = '0, a_pin_out;

    logic [1:0]  b_addr = '0;
    logic        b_wr = 1'b0;
    logic [7:0]  b_wdata = '0, b_rdata, b_pin_in = '0, b_pin_out;

    gpio_mmio #(.WIDTH(32), .HAS_SETCLR(1'b1), .REVERSED(1'b0)) u_gpio_mmio (
        .clk(clk), .rst_n(rst_n), .bus_addr(a_addr), .bus_wr(a_wr),
        .bus_wdata(a_wdata), .bus_rdata(a_rdata),
        .pin_in(a_pin_in), .pin_out(a_pin_out));

    gpio_mmio #(.WIDTH(8), .HAS_SETCLR(1'b0), .REVERSED(1'b1)) u_gpio_mmio_rev (
        .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wr(b_wr),
        .bus_wdata(b_wdata), .bus_rdata(b_rdata),
        .pin_in(b_pin_in), .pin_out(b_pin_out));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic a_write(input logic [1:0] addr, input logic [31:0] data);
        @(negedge clk);
        a_addr = addr; a_wr = 1'b1; a_wdata = data;
        @(negedge clk);
        a_wr = 1'b0; a_addr = 2'd0;
    endtask

    task automatic b_write(input logic [1:0] addr, input logic [7:0] data);
        @(negedge clk);
        b_addr = addr; b_wr = 1'b1; b_wdata = data;
        @(negedge clk);
        b_wr = 1'b0; b_addr = 2'd0;
    endtask

    task automatic a_read(input logic [1:0] addr, output logic [31:0] val);
        a_addr = addr; #1; val = a_rdata; a_addr = 2'd0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 pin_out in reset", {32'd0, a_pin_out}, 64'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pin_out after reset", {32'd0, a_pin_out}, 64'd0);
        chk("R1 rev pin_out after reset", {56'd0, b_pin_out}, 64'd0);
        a_read(2'd0, v);
        chk("R1 data read after reset", {32'd0, v}, 64'd0);
    endtask

    task automatic t_data_write();
        a_write(2'd0, 32'hA5C3_0F81);
        chk("R2 R9 load pattern 1", {32'd0, a_pin_out}, 64'hA5C3_0F81);
        a_write(2'd0, 32'h0000_0001);
        chk("R9 register bit 0 is line 0", {32'd0, a_pin_out}, 64'h1);
        a_write(2'd0, 32'hFFFF_FFFF);
        chk("R2 load all ones", {32'd0, a_pin_out}, 64'hFFFF_FFFF);
    endtask

    task automatic t_pin_read();
        logic [31:0] v;
        @(negedge clk); a_pin_in = 32'h1234_8001;
        @(negedge clk);
        a_read(2'd0, v);
        chk("R3 one edge keeps old value", {32'd0, v}, 64'd0);
        @(negedge clk);
        a_read(2'd0, v);
        chk("R3 R9 two edges give new value", {32'd0, v}, 64'h1234_8001);
    endtask

    task automatic t_set_clear();
        a_write(2'd0, 32'h0000_F00F);
        a_write(2'd1, 32'h8000_0F01);
        chk("R4 set mask", {32'd0, a_pin_out}, 64'h8000_FF0F);
        a_write(2'd2, 32'h8000_000A);
        chk("R5 clear mask", {32'd0, a_pin_out}, 64'h0000_FF05);
        a_write(2'd1, 32'h0);
        chk("R4 empty set mask", {32'd0, a_pin_out}, 64'h0000_FF05);
        a_write(2'd2, 32'hFFFF_FFFF);
        chk("R5 clear all", {32'd0, a_pin_out}, 64'h0);
    endtask

    task automatic t_hold_unused();
        logic [31:0] v;
        a_write(2'd0, 32'h5A5A_3C3C);
        @(negedge clk); a_wdata = 32'hDEAD_BEEF; a_addr = 2'd2;
        repeat (3) @(negedge clk);
        a_addr = 2'd0;
        chk("R6 hold without strobe", {32'd0, a_pin_out}, 64'h5A5A_3C3C);
        a_write(2'd3, 32'h0);
        chk("R7 write to address 3 ignored", {32'd0, a_pin_out}, 64'h5A5A_3C3C);
        a_read(2'd1, v); chk("R7 read address 1", {32'd0, v}, 64'd0);
        a_read(2'd2, v); chk("R7 read address 2", {32'd0, v}, 64'd0);
        a_read(2'd3, v); chk("R7 read address 3", {32'd0, v}, 64'd0);
    endtask

    task automatic t_reversed();
        logic [7:0] v;
        b_write(2'd0, 8'h01);
        chk("R10 register bit 0 is line 7", {56'd0, b_pin_out}, 64'h80);
        b_write(2'd0, 8'h86);
        chk("R10 pattern mirror", {56'd0, b_pin_out}, 64'h61);
        b_write(2'd1, 8'hFF);
        chk("R8 set address absent", {56'd0, b_pin_out}, 64'h61);
        b_write(2'd2, 8'hFF);
        chk("R8 clear address absent", {56'd0, b_pin_out}, 64'h61);
        @(negedge clk); b_pin_in = 8'h03;
        repeat (2) @(negedge clk);
        b_addr = 2'd0; #1; v = b_rdata;
        chk("R10 R3 read mirror", {56'd0, v}, 64'hC0);
    endtask

    initial begin
        t_reset();
        t_data_write();
        t_pin_read();
        t_set_clear();
        t_hold_unused();
        t_reversed();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule